// File: doc/BRIEF.md
# Maskable burst address counter

This block generates the word address for one port of a synchronous memory. A start address is loaded once from the address inputs. After that, the counter advances by one word on each clock edge, so a burst runs without new addresses being presented. A mask register marks the low-order address bits that take part in counting. The bits above the mask stay fixed, so the mask sets both the size and the alignment of the region in which the counter wraps.

A counter-reset input clears only the counting (unmasked) bits, which returns the burst to the start of its current region. When the counting field rolls over, an active-low wrap flag goes low and stays low until the next load or counter reset. A one-hot select routes either the live counter value or the mask value onto a readback bus. An asynchronous active-low master reset initialises the whole block, and its release is synchronised to the clock.

Top module: `burst_addr_ctr`

## Requirements
- R1: While master reset is low, and after it is released, the counter reads 0x00, the mask reads all ones (0xFF for the default 8-bit width) and cntint_n is high. Control inputs take effect from the third rising clock edge after rst_n goes high.
- R2: At a rising edge where ads_n = 0 and cnten_n = 0, with cntrst_n = 1 and mask_wr = 0, the counter takes addr_in and cntint_n returns high.
- R3: At a rising edge where cnten_n = 0 and ads_n = 1, with cntrst_n = 1 and mask_wr = 0, the masked-in bits of the counter become (count + 1) modulo 2^k, where k is the number of ones in the mask, and the bits outside the mask keep their value.
- R4: At a rising edge where cnten_n = 1, with cntrst_n = 1 and mask_wr = 0, the counter and cntint_n hold their values whatever ads_n and addr_in are.
- R5: At a rising edge where cntrst_n = 0, the bits of the counter that are inside the mask clear to zero, the bits outside it are kept, and cntint_n goes high. In that cycle, mask_wr, ads_n and cnten_n have no effect.
- R6: At a rising edge where mask_wr = 1 and cntrst_n = 1, the mask takes addr_in only if addr_in is a run of ones starting at bit 0 (zero included, that is (v & (v+1)) == 0). Any other value is rejected, and the mask keeps its previous value.
- R7: In a cycle that writes the mask (mask_wr = 1, cntrst_n = 1), the counter and cntint_n hold, even when ads_n and cnten_n are both low.
- R8: cntint_n goes low after an increment whose starting value has all masked-in bits at one. An all-zero mask counts as such a field on every increment. Once low, cntint_n stays low through further increments, holds and mask writes, until a load or a counter reset.
- R9: The readback output rb_data shows the counter when rd_sel = 2'b01, the mask when rd_sel = 2'b10, and zero when rd_sel = 2'b00. It follows rd_sel and the registers without a clock delay.
- R10: With the mask all ones, the counter steps across the whole address range and advances from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ads_n | input | 1 | Active-low address strobe, used for loading |
| cnten_n | input | 1 | Active-low counter enable |
| cntrst_n | input | 1 | Active-low counter reset (clears the masked-in bits) |
| mask_wr | input | 1 | Write addr_in into the mask register |
| addr_in | input | AW | External address or mask value |
| rd_sel | input | 2 | One-hot readback select: bit 0 counter, bit 1 mask |
| addr_out | output | AW | Current counter value, used as the memory address |
| cntint_n | output | 1 | Active-low, sticky wrap flag |
| rb_data | output | AW | Readback value selected by rd_sel |

## Verification
The assertions assume that rd_sel never has both bits set, that inputs are known once reset is released, and that the mask register only ever holds a contiguous run of low-order ones. The last point holds because the mask module filters every write. The stimulus changes inputs only on falling edges and drives rd_sel with 00, 01 or 10 only. It presents every possible 8-bit value as a mask write, so both rejected and accepted writes are exercised without breaking the contiguity that the increment and wrap properties rely on. Bursts are run under every legal mask width, and each is long enough to wrap at least once.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_LOAD = 3'd2,
    OP_MASK = 3'd3,
    OP_CRST = 3'd4
  } bac_op_e;

  localparam int RB_SEL_W  = 2;
  localparam int RB_CNT_B  = 0;
  localparam int RB_MASK_B = 1;

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bac_mask_reg.sv
module bac_mask_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] mask
);

  logic [AW-1:0] mask_q;
  logic [AW-1:0] mask_d;
  logic [AW-1:0] wdata_plus1;
  logic          wdata_ok;
  logic          mask_en;

  // A legal mask is a run of ones from bit 0: adding one clears every set bit.
  always_comb begin
    wdata_plus1 = wdata + 1'b1;
    wdata_ok    = ((wdata & wdata_plus1) == '0);
    mask_en     = wr_en && wdata_ok;
    mask_d      = mask_en ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

  assert_mask_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata_ok) |=> $stable(mask_q));

  assert_mask_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata_ok) |=> (mask_q == $past(wdata)));

  assert_no_idle_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bac_op_e       op,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] cnt,
  output logic          cntint_n
);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic [AW-1:0] cnt_plus1;
  logic          int_q;
  logic          int_d;
  logic          field_full;
  logic          cnt_en;

  always_comb begin
    cnt_plus1  = cnt_q + 1'b1;
    field_full = ((cnt_q & mask) == mask);
    cnt_d      = cnt_q;
    int_d      = int_q;
    cnt_en     = 1'b0;
    case (op)
      OP_CRST: begin
        cnt_d  = cnt_q & ~mask;
        int_d  = 1'b1;
        cnt_en = 1'b1;
      end
      OP_LOAD: begin
        cnt_d  = addr_in;
        int_d  = 1'b1;
        cnt_en = 1'b1;
      end
      OP_INC: begin
        cnt_d  = (cnt_q & ~mask) | (cnt_plus1 & mask);
        cnt_en = 1'b1;
        if (field_full) begin
          int_d = 1'b0;
        end
      end
      default: begin
        cnt_d  = cnt_q;
        int_d  = int_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      int_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      int_q <= int_d;
    end
  end

  assign cnt      = cnt_q;
  assign cntint_n = int_q;

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (cnt_q == $past(addr_in)) && int_q);

  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> ((cnt_q & ~$past(mask)) == $past(cnt_q & ~mask)));

  assert_hold_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(cnt_q) && $stable(int_q)));

  assert_crst_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CRST) |=> (((cnt_q & $past(mask)) == '0) && int_q));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MASK) |=> ($stable(cnt_q) && $stable(int_q)));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_INC) && ((cnt_q & mask) == mask)) |=> !int_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_q && (op != OP_LOAD) && (op != OP_CRST)) |=> !int_q);

endmodule

// File: rtl/bac_readback.sv
module bac_readback
  import bac_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [RB_SEL_W-1:0] sel,
  input  logic [AW-1:0]       cnt,
  input  logic [AW-1:0]       mask,
  output logic [AW-1:0]       rb
);

  logic [AW-1:0] src [RB_SEL_W];
  logic [AW-1:0] gated [RB_SEL_W];

  assign src[RB_CNT_B]  = cnt;
  assign src[RB_MASK_B] = mask;

  for (genvar g = 0; g < RB_SEL_W; g++) begin : g_gate
    assign gated[g] = {AW{sel[g]}} & src[g];
  end

  always_comb begin
    rb = '0;
    for (int i = 0; i < RB_SEL_W; i++) begin
      rb = rb | gated[i];
    end
  end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ads_n,
  input  logic                cnten_n,
  input  logic                cntrst_n,
  input  logic                mask_wr,
  input  logic [AW-1:0]       addr_in,
  input  logic [RB_SEL_W-1:0] rd_sel,
  output logic [AW-1:0]       addr_out,
  output logic                cntint_n,
  output logic [AW-1:0]       rb_data
);

  logic          rst_sync_n;
  bac_op_e       op;
  logic [AW-1:0] mask;
  logic [AW-1:0] cnt;

  bac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Priority decode: counter reset, mask write, load, increment, hold.
  always_comb begin
    if (!cntrst_n) begin
      op = OP_CRST;
    end else if (mask_wr) begin
      op = OP_MASK;
    end else if (!cnten_n && !ads_n) begin
      op = OP_LOAD;
    end else if (!cnten_n) begin
      op = OP_INC;
    end else begin
      op = OP_HOLD;
    end
  end

  bac_mask_reg #(.AW(AW)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (op == OP_MASK),
    .wdata (addr_in),
    .mask  (mask)
  );

  bac_counter #(.AW(AW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .addr_in  (addr_in),
    .mask     (mask),
    .cnt      (cnt),
    .cntint_n (cntint_n)
  );

  bac_readback #(.AW(AW)) u_rb (
    .sel  (rd_sel),
    .cnt  (cnt),
    .mask (mask),
    .rb   (rb_data)
  );

  assign addr_out = cnt;

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(rd_sel));

  assert_crst_first_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cntrst_n && mask_wr) |=> $stable(mask));

endmodule

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;

  localparam int  AW    = 8;
  localparam time TCLK  = 8ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ads_n, cnten_n, cntrst_n, mask_wr;
  logic [AW-1:0] addr_in;
  logic [1:0]    rd_sel;
  logic [AW-1:0] addr_out;
  logic          cntint_n;
  logic [AW-1:0] rb_data;

  int nvec = 0;
  int nfail = 0;

  logic [AW-1:0] m_cnt, m_mask;
  logic          m_int;

  always #(TCLK/2) clk = ~clk;

  burst_addr_ctr i_burst_addr_ctr (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cnten_n(cnten_n),
    .cntrst_n(cntrst_n), .mask_wr(mask_wr), .addr_in(addr_in),
    .rd_sel(rd_sel), .addr_out(addr_out), .cntint_n(cntint_n),
    .rb_data(rb_data)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Caller is at a falling edge; inputs are driven, one rising edge passes,
  // the model steps, and outputs are compared at the next falling edge.
  task automatic apply(input string tag, input logic ads, input logic cen,
                       input logic crst, input logic mwr, input logic [AW-1:0] a);
    logic [AW-1:0] plus1;
    ads_n = ads; cnten_n = cen; cntrst_n = crst; mask_wr = mwr; addr_in = a;
    @(posedge clk);
    plus1 = a + 8'd1;
    if (!crst) begin
      m_cnt = m_cnt & ~m_mask; m_int = 1'b1;
    end else if (mwr) begin
      if ((a & plus1) == 8'd0) m_mask = a;
    end else if (!cen && !ads) begin
      m_cnt = a; m_int = 1'b1;
    end else if (!cen) begin
      if ((m_cnt & m_mask) == m_mask) m_int = 1'b0;
      m_cnt = (m_cnt & ~m_mask) | ((m_cnt + 8'd1) & m_mask);
    end
    @(negedge clk);
    ads_n = 1'b1; cnten_n = 1'b1; cntrst_n = 1'b1; mask_wr = 1'b0;
    check(tag, addr_out, m_cnt);
    check(tag, {7'd0, cntint_n}, {7'd0, m_int});
  endtask

  task automatic check_rb(input string tag);
    rd_sel = 2'b10; #1;
    check(tag, rb_data, m_mask);
    rd_sel = 2'b01; #1;
    check(tag, rb_data, m_cnt);
    rd_sel = 2'b00; #1;
    check(tag, rb_data, 8'h00);
  endtask

  initial begin
    #(TCLK * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ads_n = 1'b1; cnten_n = 1'b1; cntrst_n = 1'b1;
    mask_wr = 1'b0; addr_in = '0; rd_sel = 2'b00;
    m_cnt = 8'h00; m_mask = 8'hFF; m_int = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", addr_out, 8'h00);
    check("R1", {7'd0, cntint_n}, 8'h01);
    rd_sel = 2'b10; #1; check("R1", rb_data, 8'hFF); rd_sel = 2'b00;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", addr_out, 8'h00);
    check_rb("R1");

    // R6: every possible mask value, restoring all ones after each
    for (int v = 0; v < 256; v++) begin
      apply("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
      apply("R6", 1'b1, 1'b1, 1'b1, 1'b1, v[7:0]);
      rd_sel = 2'b10; #1;
      check("R6", rb_data, m_mask);
      rd_sel = 2'b00;
    end
    apply("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);

    // R2: load every address under the full mask
    for (int v = 0; v < 256; v++) begin
      apply("R2", 1'b0, 1'b0, 1'b1, 1'b0, v[7:0]);
    end

    // R10: full-range stepping across all ones to zero
    apply("R10", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFC);
    for (int i = 0; i < 6; i++) apply("R10", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R10", addr_out, 8'h02);

    // R3 and R8: bursts under every legal mask width, each wrapping
    for (int k = 0; k <= 8; k++) begin
      logic [AW-1:0] mk;
      logic [AW-1:0] start;
      mk = 8'((9'd1 << k) - 9'd1);
      start = 8'((8'hA5 + k * 37) & 8'hFF);
      apply("R6", 1'b1, 1'b1, 1'b1, 1'b1, mk);
      apply("R2", 1'b0, 1'b0, 1'b1, 1'b0, start);
      for (int i = 0; i < (1 << k) + 3; i++) begin
        apply("R3", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        check("R3", addr_out & ~mk, start & ~mk);
        if (i == 2) begin
          // R4: hold with strobe low and counter enable high
          apply("R4", 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C);
        end
      end
      check("R8", {7'd0, cntint_n}, 8'h00);
      // R8: the flag survives a mask write and a hold
      apply("R8", 1'b1, 1'b1, 1'b1, 1'b1, mk);
      apply("R8", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R8", {7'd0, cntint_n}, 8'h00);
      // R5: counter reset clears the field and the flag
      apply("R5", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R5", addr_out, start & ~mk);
      check_rb("R9");
    end

    // R5 priority: counter reset beats a mask write and a load
    apply("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'h0F);
    apply("R2", 1'b0, 1'b0, 1'b1, 1'b0, 8'hB7);
    apply("R5", 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    check("R5", addr_out, 8'hB0);
    rd_sel = 2'b10; #1; check("R5", rb_data, 8'h0F); rd_sel = 2'b00;

    // R7: a mask write beats a load and an increment
    apply("R2", 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    apply("R7", 1'b0, 1'b0, 1'b1, 1'b1, 8'h07);
    check("R7", addr_out, 8'h5A);
    apply("R7", 1'b1, 1'b0, 1'b1, 1'b1, 8'h66);
    check("R7", addr_out, 8'h5A);

    // R9: readback of specific values
    check_rb("R9");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule